// File: doc/BRIEF.md
# Dual Clock Scan Sequencer

This block paces a multichannel converter from two event streams. A rising edge on the scan clock input opens an acquisition window. Each rising edge on the conversion clock input that falls inside an open window selects the next channel of a configured list. The block presents that channel's index and its gain code from an internal per-channel gain table. One cycle later it raises a single-cycle convert strobe. The window closes once the configured number of channels has been converted. Conversion edges after that are ignored until the next scan edge.

The channel list starts at a programmable first channel and advances by one per conversion. It wraps modulo 16 in single-ended mode and modulo 8 in differential mode. In single-clock mode the scan input is disregarded and the conversion clock does both jobs: an edge that arrives while the window is closed opens it and also starts the first conversion. An enable input gates the whole sequencer. The multiplexer, the converter, sample storage and triggering sit outside the block.

The controller has five states. IDLE means disabled. WAIT means the window is closed. ARMED means the window is open and idle. SETUP means the channel and gain are being presented. FIRE means the strobe is high. Transitions:
- enable (IDLE→WAIT)
- open (WAIT→ARMED on a scan edge)
- single-open (WAIT→SETUP on a conversion edge in single-clock mode)
- select (ARMED→SETUP on a conversion edge)
- settle (SETUP→FIRE, unconditional)
- next (FIRE→ARMED while channels remain)
- close (FIRE→WAIT after the last channel)
- disable (any state→IDLE when enable is low)

Top module: `dual_clk_scan_seq`

## Requirements
- R1: After reset, conv_strobe, window_open, overrun, chan_idx and gain_code are all 0.
- R2: In dual-clock mode, a rising edge of scan_clk_in while the window is closed makes window_open high from the clock edge that samples it.
- R3: A rising edge of conv_clk_in sampled at edge E inside an open window sets chan_idx and gain_code at E; conv_strobe is high for exactly the one cycle following edge E+1, with chan_idx and gain_code unchanged from the previous cycle.
- R4: Rising edges of conv_clk_in while the window is closed (dual-clock mode) produce no strobe.
- R5: The k-th conversion of a window (k from 0) uses channel (first_chan + k) mod N, where N is 16 when diff_mode is 0 and 8 when diff_mode is 1. window_open falls at the edge that ends the strobe of the last conversion.
- R6: A chan_count of 0 acts as 1, and a chan_count above N acts as N.
- R7: A write with gain_we high stores gain_wdata for channel gain_waddr; each conversion outputs the stored code of its own channel.
- R8: A scan edge while the window is open sets overrun, which stays high until acq_en falls; the window is not restarted and the list continues.
- R9: With single_clk high, scan_clk_in has no effect. A conversion edge while the window is closed opens the window and converts first_chan. overrun is never set in this mode.
- R10: acq_en low closes the window, clears overrun and suppresses strobes from the next edge; scan edges are ignored while disabled.
- R11: A conversion edge sampled while a conversion is being set up or strobed is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_en | input | 1 | Acquisition enable |
| single_clk | input | 1 | 1: conversion clock also serves as scan clock |
| diff_mode | input | 1 | 1: 8 differential channels, 0: 16 single-ended |
| scan_clk_in | input | 1 | Scan clock, rising edge opens a window |
| conv_clk_in | input | 1 | Conversion clock, rising edge requests a conversion |
| first_chan | input | 4 | First channel of the list, latched when a window opens |
| chan_count | input | 5 | Channels per window, latched when a window opens |
| gain_we | input | 1 | Gain table write enable |
| gain_waddr | input | 4 | Gain table write channel |
| gain_wdata | input | 3 | Gain code to store |
| conv_strobe | output | 1 | One-cycle converter start |
| chan_idx | output | 4 | Channel for the pending conversion |
| gain_code | output | 3 | Gain code for the pending conversion |
| window_open | output | 1 | Acquisition window is open |
| overrun | output | 1 | Sticky: scan edge arrived inside an open window |

## Verification
Edges on the clock inputs are driven at falling clock edges and held for one cycle, so each input edge is sampled at a single rising edge E. After E, window_open, chan_idx and gain_code are already valid. The strobe is due one cycle later and is gone one cycle after that. A closing window shows up at the third sample. Each check samples at the falling edge that follows the rising edge where its result is due. Checks for ignored edges watch the strobe and window outputs over the full three-cycle span in which a response could appear.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_ARMED = 3'd2,
        ST_SETUP = 3'd3,
        ST_FIRE  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig_in[i];
        end
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/gain_table.sv
module gain_table #(
    parameter int NUM_CH = 16,
    parameter int GAIN_W = 3,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [GAIN_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [GAIN_W-1:0] rdata
);
    logic [GAIN_W-1:0] mem_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[c] <= '0;
            else if (we && (waddr == IDX_W'(c)))
                mem_q[c] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/chan_stepper.sv
module chan_stepper #(
    parameter int NUM_CH = 16,
    parameter int GAIN_W = 3,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_win,
    input  logic              load,
    input  logic              diff_mode,
    input  logic [IDX_W-1:0]  first_chan,
    input  logic [CNT_W-1:0]  chan_count,
    input  logic [GAIN_W-1:0] tbl_gain,
    output logic [IDX_W-1:0]  tbl_addr,
    output logic [IDX_W-1:0]  chan_idx,
    output logic [GAIN_W-1:0] gain_code,
    output logic              all_done
);
    localparam int HALF_CH = NUM_CH / 2;
    localparam logic [IDX_W-1:0] MASK_SE   = IDX_W'(NUM_CH - 1);
    localparam logic [IDX_W-1:0] MASK_DIFF = IDX_W'(HALF_CH - 1);

    logic [IDX_W-1:0] first_q;
    logic [CNT_W-1:0] lim_q;
    logic             diff_q;
    logic [CNT_W-1:0] pos_q;
    logic [IDX_W-1:0] chan_q;
    logic [GAIN_W-1:0] gain_q;

    logic [IDX_W-1:0] first_n;
    logic [CNT_W-1:0] lim_n;
    logic             diff_n;
    logic [CNT_W-1:0] pos_base;
    logic [IDX_W-1:0] mask_n;
    logic [CNT_W-1:0] span_n;
    logic [CNT_W-1:0] sum_n;

    always_comb begin
        span_n = diff_mode ? CNT_W'(HALF_CH) : CNT_W'(NUM_CH);
        if (chan_count == '0)
            lim_n = CNT_W'(1);
        else if (chan_count > span_n)
            lim_n = span_n;
        else
            lim_n = chan_count;

        if (open_win) begin
            first_n  = first_chan;
            diff_n   = diff_mode;
            pos_base = '0;
        end else begin
            first_n  = first_q;
            diff_n   = diff_q;
            pos_base = pos_q;
        end
        mask_n   = diff_n ? MASK_DIFF : MASK_SE;
        sum_n    = {1'b0, first_n} + pos_base;
        tbl_addr = sum_n[IDX_W-1:0] & mask_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            lim_q   <= CNT_W'(1);
            diff_q  <= 1'b0;
            pos_q   <= '0;
            chan_q  <= '0;
            gain_q  <= '0;
        end else begin
            if (open_win) begin
                first_q <= first_chan;
                lim_q   <= lim_n;
                diff_q  <= diff_mode;
                pos_q   <= '0;
            end
            if (load) begin
                chan_q <= tbl_addr;
                gain_q <= tbl_gain;
                pos_q  <= pos_base + CNT_W'(1);
            end
        end
    end

    assign chan_idx  = chan_q;
    assign gain_code = gain_q;
    assign all_done  = (pos_q >= lim_q);
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq_en,
    input  logic single_clk,
    input  logic scan_ev,
    input  logic conv_ev,
    input  logic all_done,
    output logic open_win,
    output logic load,
    output logic conv_strobe,
    output logic window_open,
    output logic overrun
);
    seq_state_e state_q, state_n;
    logic       overrun_set;

    always_comb begin
        state_n     = state_q;
        open_win    = 1'b0;
        load        = 1'b0;
        overrun_set = 1'b0;
        if (!acq_en) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_WAIT;
                ST_WAIT: begin
                    if (single_clk) begin
                        if (conv_ev) begin
                            state_n  = ST_SETUP;
                            open_win = 1'b1;
                            load     = 1'b1;
                        end
                    end else if (scan_ev) begin
                        state_n  = ST_ARMED;
                        open_win = 1'b1;
                    end
                end
                ST_ARMED: begin
                    if (conv_ev) begin
                        state_n = ST_SETUP;
                        load    = 1'b1;
                    end
                end
                ST_SETUP: state_n = ST_FIRE;
                ST_FIRE:  state_n = all_done ? ST_WAIT : ST_ARMED;
                default:  state_n = ST_IDLE;
            endcase
            if (!single_clk && scan_ev &&
                (state_q == ST_ARMED || state_q == ST_SETUP || state_q == ST_FIRE))
                overrun_set = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            overrun <= 1'b0;
        end else begin
            state_q <= state_n;
            if (!acq_en)
                overrun <= 1'b0;
            else if (overrun_set)
                overrun <= 1'b1;
        end
    end

    always_comb begin
        conv_strobe = 1'b0;
        window_open = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: ;
            ST_ARMED, ST_SETUP: window_open = 1'b1;
            ST_FIRE: begin
                window_open = 1'b1;
                conv_strobe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_clk_scan_seq.sv
module dual_clk_scan_seq #(
    parameter int NUM_CH = 16,
    parameter int GAIN_W = 3,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_en,
    input  logic              single_clk,
    input  logic              diff_mode,
    input  logic              scan_clk_in,
    input  logic              conv_clk_in,
    input  logic [IDX_W-1:0]  first_chan,
    input  logic [CNT_W-1:0]  chan_count,
    input  logic              gain_we,
    input  logic [IDX_W-1:0]  gain_waddr,
    input  logic [GAIN_W-1:0] gain_wdata,
    output logic              conv_strobe,
    output logic [IDX_W-1:0]  chan_idx,
    output logic [GAIN_W-1:0] gain_code,
    output logic              window_open,
    output logic              overrun
);
    logic [1:0]        rises;
    logic              open_win, load, all_done;
    logic [IDX_W-1:0]  tbl_addr;
    logic [GAIN_W-1:0] tbl_gain;

    rise_detect #(.WIDTH(2)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({conv_clk_in, scan_clk_in}),
        .rise   (rises)
    );

    scan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .acq_en      (acq_en),
        .single_clk  (single_clk),
        .scan_ev     (rises[0]),
        .conv_ev     (rises[1]),
        .all_done    (all_done),
        .open_win    (open_win),
        .load        (load),
        .conv_strobe (conv_strobe),
        .window_open (window_open),
        .overrun     (overrun)
    );

    gain_table #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W)) u_gain (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gain_we),
        .waddr (gain_waddr),
        .wdata (gain_wdata),
        .raddr (tbl_addr),
        .rdata (tbl_gain)
    );

    chan_stepper #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_win   (open_win),
        .load       (load),
        .diff_mode  (diff_mode),
        .first_chan (first_chan),
        .chan_count (chan_count),
        .tbl_gain   (tbl_gain),
        .tbl_addr   (tbl_addr),
        .chan_idx   (chan_idx),
        .gain_code  (gain_code),
        .all_done   (all_done)
    );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int IDX_W  = 4,
    parameter int GAIN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_en,
    input logic              conv_strobe,
    input logic [IDX_W-1:0]  chan_idx,
    input logic [GAIN_W-1:0] gain_code,
    input logic              window_open,
    input logic              overrun
);
    p_strobe_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> window_open);

    p_settled_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> ($stable(chan_idx) && $stable(gain_code)));

    p_one_cycle_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);

    p_disable_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_en |=> (!window_open && !overrun && !conv_strobe));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && acq_en) |=> overrun);

    p_overrun_needs_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(window_open));
endmodule

bind dual_clk_scan_seq scan_seq_chk #(.IDX_W(IDX_W), .GAIN_W(GAIN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_en      (acq_en),
    .conv_strobe (conv_strobe),
    .chan_idx    (chan_idx),
    .gain_code   (gain_code),
    .window_open (window_open),
    .overrun     (overrun)
);

// File: tb/tb_dual_clk_scan_seq.sv
module tb_dual_clk_scan_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acq_en = 1'b0, single_clk = 1'b0, diff_mode = 1'b0;
    logic       scan_clk_in = 1'b0, conv_clk_in = 1'b0;
    logic [3:0] first_chan = '0;
    logic [4:0] chan_count = '0;
    logic       gain_we = 1'b0;
    logic [3:0] gain_waddr = '0;
    logic [2:0] gain_wdata = '0;
    logic       conv_strobe, window_open, overrun;
    logic [3:0] chan_idx;
    logic [2:0] gain_code;

    int checks = 0;
    int errors = 0;
    logic [2:0] gtab [16];

    always #2.5 clk = ~clk;

    dual_clk_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .single_clk(single_clk),
        .diff_mode(diff_mode), .scan_clk_in(scan_clk_in), .conv_clk_in(conv_clk_in),
        .first_chan(first_chan), .chan_count(chan_count), .gain_we(gain_we),
        .gain_waddr(gain_waddr), .gain_wdata(gain_wdata), .conv_strobe(conv_strobe),
        .chan_idx(chan_idx), .gain_code(gain_code), .window_open(window_open),
        .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_gain(input int ch, input int g);
        @(negedge clk);
        gain_we = 1'b1; gain_waddr = 4'(ch); gain_wdata = 3'(g);
        gtab[ch] = 3'(g);
        @(negedge clk);
        gain_we = 1'b0;
    endtask

    task automatic scan_pulse();
        @(negedge clk); scan_clk_in = 1'b1;
        @(negedge clk); scan_clk_in = 1'b0;
    endtask

    // Conversion edge; checks select, settle lead and one-cycle strobe (R3, R5, R7)
    task automatic conv_expect(input int ch, input string req);
        @(negedge clk); conv_clk_in = 1'b1;
        @(negedge clk); conv_clk_in = 1'b0;
        chk({req, " chan"}, int'(chan_idx), ch);
        chk("R7 gain", int'(gain_code), int'(gtab[ch]));
        chk("R3 strobe lead", int'(conv_strobe), 0);
        @(negedge clk);
        chk("R3 strobe", int'(conv_strobe), 1);
        @(negedge clk);
        chk("R3 strobe end", int'(conv_strobe), 0);
    endtask

    // Conversion edge that must be ignored (R4)
    task automatic conv_ignored(input string req);
        int seen = 0;
        @(negedge clk); conv_clk_in = 1'b1;
        @(negedge clk); conv_clk_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            seen += int'(conv_strobe);
            @(negedge clk);
        end
        chk(req, seen, 0);
    endtask

    task automatic cfg(input int f, input int n, input logic d);
        first_chan = 4'(f); chan_count = 5'(n); diff_mode = d;
    endtask

    task automatic re_enable();
        @(negedge clk); acq_en = 1'b0;
        @(negedge clk); acq_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 strobe", int'(conv_strobe), 0);
        chk("R1 window", int'(window_open), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 chan", int'(chan_idx), 0);
        chk("R1 gain", int'(gain_code), 0);
    endtask

    task automatic t_basic();
        cfg(3, 3, 1'b0);
        conv_ignored("R4 closed window");
        scan_pulse();
        chk("R2 window opens", int'(window_open), 1);
        conv_expect(3, "R5");
        conv_expect(4, "R5");
        conv_expect(5, "R5");
        chk("R5 window closed", int'(window_open), 0);
        conv_ignored("R4 after close");
    endtask

    task automatic t_wrap();
        cfg(14, 4, 1'b0);
        scan_pulse();
        conv_expect(14, "R5 wrap");
        conv_expect(15, "R5 wrap");
        conv_expect(0, "R5 wrap");
        conv_expect(1, "R5 wrap");
        chk("R5 wrap close", int'(window_open), 0);
    endtask

    task automatic t_diff();
        cfg(6, 4, 1'b1);
        scan_pulse();
        conv_expect(6, "R5 diff");
        conv_expect(7, "R5 diff");
        conv_expect(0, "R5 diff");
        conv_expect(1, "R5 diff");
        chk("R5 diff close", int'(window_open), 0);
    endtask

    task automatic t_clamp();
        cfg(9, 0, 1'b0);
        scan_pulse();
        conv_expect(9, "R6 zero count");
        chk("R6 zero count closes", int'(window_open), 0);
        cfg(0, 20, 1'b1);
        scan_pulse();
        for (int c = 0; c < 8; c++) conv_expect(c, "R6 clamp");
        chk("R6 clamp closes", int'(window_open), 0);
    endtask

    task automatic t_gain_rewrite();
        wr_gain(3, 6);
        cfg(3, 1, 1'b0);
        scan_pulse();
        conv_expect(3, "R7 rewrite");
    endtask

    task automatic t_overrun();
        cfg(2, 2, 1'b0);
        scan_pulse();
        conv_expect(2, "R8");
        chk("R8 no overrun yet", int'(overrun), 0);
        scan_pulse();
        chk("R8 overrun set", int'(overrun), 1);
        chk("R8 window kept", int'(window_open), 1);
        conv_expect(3, "R8 not restarted");
        chk("R8 closes", int'(window_open), 0);
        chk("R8 sticky", int'(overrun), 1);
    endtask

    task automatic t_single();
        re_enable();
        chk("R10 overrun cleared", int'(overrun), 0);
        single_clk = 1'b1;
        cfg(9, 2, 1'b0);
        scan_pulse();
        @(negedge clk);
        chk("R9 scan ignored", int'(window_open), 0);
        conv_expect(9, "R9 opens");
        chk("R9 window open", int'(window_open), 1);
        conv_expect(10, "R9");
        chk("R9 closes", int'(window_open), 0);
        chk("R9 no overrun", int'(overrun), 0);
        single_clk = 1'b0;
    endtask

    task automatic t_back_to_back();
        int seen = 0;
        cfg(0, 2, 1'b0);
        scan_pulse();
        @(negedge clk); conv_clk_in = 1'b1;
        @(negedge clk); conv_clk_in = 1'b0;
        @(negedge clk); conv_clk_in = 1'b1;
        seen += int'(conv_strobe);
        @(negedge clk); conv_clk_in = 1'b0;
        for (int i = 0; i < 4; i++) begin
            seen += int'(conv_strobe);
            @(negedge clk);
        end
        chk("R11 one strobe", seen, 1);
        chk("R11 window still open", int'(window_open), 1);
    endtask

    task automatic t_disable();
        scan_pulse();
        chk("R8 overrun before disable", int'(overrun), 1);
        @(negedge clk); acq_en = 1'b0;
        @(negedge clk);
        chk("R10 window closed", int'(window_open), 0);
        chk("R10 overrun clear", int'(overrun), 0);
        scan_pulse();
        chk("R10 scan ignored", int'(window_open), 0);
        conv_ignored("R10 no strobe");
        acq_en = 1'b1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 16; c++) gtab[c] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        for (int c = 0; c < 16; c++) wr_gain(c, (c * 5 + 1) % 8);
        @(negedge clk); acq_en = 1'b1;
        @(negedge clk);
        t_basic();
        t_wrap();
        t_diff();
        t_clamp();
        t_gain_rewrite();
        t_overrun();
        t_single();
        t_back_to_back();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule